// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control sequencer for a processor datapath that shares one memory between instructions and data and uses one ALU for every arithmetic step. Each instruction goes through several clock cycles. The first two are always the same: an instruction fetch, then a decode step. After that, the opcode selects a path for one of four instruction classes: word load, word store, register-to-register ALU operation and branch-on-equal. Each path runs until its instruction is complete and then goes back to fetch.

The sequencer is a Moore machine. The datapath control levels depend only on the current phase. The opcode is used only to choose the next phase, which happens at two points: the decode phase and the address phase. The opcode is a plain level input taken from the datapath's instruction register. Every output is a plain control level. There is no data stream, so the block has no valid/ready handshake and never applies back-pressure.

The encodings below are used by the outputs:
- `alu_b_sel`: 0 selects register operand B, 1 selects the constant 4, 2 selects the sign-extended immediate, 3 selects the sign-extended immediate shifted left by two.
- `alu_mode`: 0 selects add, 1 selects subtract, 2 lets the funct field choose the operation.
- `alu_a_sel`: 0 selects the PC, 1 selects register operand A.
- `mem_addr_sel`: 0 selects the PC, 1 selects the ALU result register.
- `wb_data_sel`: 1 selects memory data, 0 selects the ALU result.
- `rf_dst_sel`: 1 selects the rd field, 0 selects the rt field.
- `pc_next_sel`: 0 selects the ALU output, 1 selects the ALU result register.

Opcode values:
- register form 0x00
- load 0x23
- store 0x2B
- branch 0x04

Top module: `mc_ctrl_fsm`

## Requirements
- R1: Synchronous reset `rst` puts the sequencer into the fetch phase at the next rising edge. This applies from any phase. While reset is held, the outputs show the fetch levels.
- R2: In the fetch phase, `mem_rd`, `ir_ld` and `pc_wr` are 1 and `alu_b_sel`=1. Every other output is 0. The next phase is always decode.
- R3: In the decode phase, `alu_b_sel`=3 and every other output is 0. Opcodes 0x23 and 0x2B go next to the address phase. Opcode 0x00 goes to the execute phase. Opcode 0x04 goes to the branch phase.
- R4: In the address phase, `alu_a_sel`=1 and `alu_b_sel`=2, and every other output is 0. Opcode 0x23 goes next to the memory-read phase. Opcode 0x2B goes to the memory-write phase.
- R5: In the memory-read phase, `mem_rd`=1 and `mem_addr_sel`=1, and every other output is 0. The next phase is load writeback, where `rf_wr`=1 and `wb_data_sel`=1 and every other output is 0. After load writeback the sequencer goes back to fetch, so a load takes 5 cycles.
- R6: In the memory-write phase, `mem_wr`=1 and `mem_addr_sel`=1, and every other output is 0. The sequencer then goes back to fetch, so a store takes 4 cycles.
- R7: In the execute phase, `alu_a_sel`=1, `alu_b_sel`=0 and `alu_mode`=2, and every other output is 0. The next phase is register writeback, where `rf_wr`=1 and `rf_dst_sel`=1 and every other output is 0. After register writeback the sequencer goes back to fetch.
- R8: In the branch phase, `alu_a_sel`=1, `alu_mode`=1, `pc_wr_cond`=1 and `pc_next_sel`=1, and every other output is 0. The sequencer then goes back to fetch, so a branch takes 3 cycles.
- R9: Any opcode other than the four listed makes the decode phase go straight back to fetch.
- R10: The opcode has no effect in any phase except decode and address. Changing it in those other phases does not change the output sequence.
- R11: `mem_rd` and `mem_wr` are never 1 in the same cycle. `pc_wr` and `pc_wr_cond` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field from the instruction register |
| pc_wr | output | 1 | Unconditional PC update |
| pc_wr_cond | output | 1 | PC update gated by the ALU zero flag |
| mem_addr_sel | output | 1 | Memory address source |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_ld | output | 1 | Instruction register load |
| wb_data_sel | output | 1 | Register write data source |
| pc_next_sel | output | 1 | PC next-value source |
| alu_mode | output | 2 | ALU operation class |
| alu_a_sel | output | 1 | ALU first operand source |
| alu_b_sel | output | 2 | ALU second operand source |
| rf_wr | output | 1 | Register file write enable |
| rf_dst_sel | output | 1 | Register file destination field select |

## Verification
In the fetch phase, two functions act in the same cycle: the instruction is read into the instruction register, and the PC is advanced by the ALU. In the decode phase, the branch target is computed while the opcode selects the next path. The bench covers these by running every instruction class one after another and comparing the complete control word in every cycle, including the fetch that follows each class. It also changes the opcode during the phases that must ignore it, and checks that the control word sequence stays as expected. A reset applied in the middle of a load has to show the fetch levels in the cycle that follows.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  localparam int PHASE_W = 4;

  typedef enum logic [PHASE_W-1:0] {
    PH_FETCH   = 4'd0,
    PH_DECODE  = 4'd1,
    PH_ADDR    = 4'd2,
    PH_MEMRD   = 4'd3,
    PH_LDWB    = 4'd4,
    PH_MEMWR   = 4'd5,
    PH_EXEC    = 4'd6,
    PH_RWB     = 4'd7,
    PH_BRANCH  = 4'd8
  } phase_e;

  typedef enum logic [2:0] {
    CL_RTYPE,
    CL_LOAD,
    CL_STORE,
    CL_BRANCH,
    CL_OTHER
  } instr_class_e;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       mem_addr_sel;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_ld;
    logic       wb_data_sel;
    logic       pc_next_sel;
    logic [1:0] alu_mode;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic       rf_wr;
    logic       rf_dst_sel;
  } ctrl_word_t;

  localparam logic [1:0] ALU_ADD   = 2'd0;
  localparam logic [1:0] ALU_SUB   = 2'd1;
  localparam logic [1:0] ALU_FUNCT = 2'd2;

  localparam logic [1:0] SRCB_REG  = 2'd0;
  localparam logic [1:0] SRCB_FOUR = 2'd1;
  localparam logic [1:0] SRCB_IMM  = 2'd2;
  localparam logic [1:0] SRCB_IMMS = 2'd3;

endpackage

// File: rtl/mc_opc_decode.sv
module mc_opc_decode
  import mc_ctrl_pkg::*;
#(
  parameter int               OPC_W      = 6,
  parameter logic [OPC_W-1:0] OPC_RTYPE  = 6'h00,
  parameter logic [OPC_W-1:0] OPC_LOAD   = 6'h23,
  parameter logic [OPC_W-1:0] OPC_STORE  = 6'h2B,
  parameter logic [OPC_W-1:0] OPC_BRANCH = 6'h04
) (
  input  logic [OPC_W-1:0] opcode,
  output instr_class_e     cls
);

  always_comb begin
    if (opcode == OPC_RTYPE)       cls = CL_RTYPE;
    else if (opcode == OPC_LOAD)   cls = CL_LOAD;
    else if (opcode == OPC_STORE)  cls = CL_STORE;
    else if (opcode == OPC_BRANCH) cls = CL_BRANCH;
    else                           cls = CL_OTHER;
  end

endmodule

// File: rtl/mc_next_phase.sv
module mc_next_phase
  import mc_ctrl_pkg::*;
(
  input  phase_e       cur,
  input  instr_class_e cls,
  output phase_e       nxt
);

  always_comb begin
    nxt = PH_FETCH;
    case (cur)
      PH_FETCH: nxt = PH_DECODE;
      PH_DECODE: begin
        case (cls)
          CL_LOAD, CL_STORE: nxt = PH_ADDR;
          CL_RTYPE:          nxt = PH_EXEC;
          CL_BRANCH:         nxt = PH_BRANCH;
          default:           nxt = PH_FETCH;
        endcase
      end
      PH_ADDR: begin
        case (cls)
          CL_LOAD:  nxt = PH_MEMRD;
          CL_STORE: nxt = PH_MEMWR;
          default:  nxt = PH_FETCH;
        endcase
      end
      PH_MEMRD: nxt = PH_LDWB;
      PH_EXEC:  nxt = PH_RWB;
      default:  nxt = PH_FETCH;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_outputs.sv
module mc_ctrl_outputs
  import mc_ctrl_pkg::*;
(
  input  phase_e     cur,
  output ctrl_word_t ctrl
);

  always_comb begin
    ctrl = '0;
    case (cur)
      PH_FETCH: begin
        ctrl.mem_rd    = 1'b1;
        ctrl.ir_ld     = 1'b1;
        ctrl.pc_wr     = 1'b1;
        ctrl.alu_b_sel = SRCB_FOUR;
        ctrl.alu_mode  = ALU_ADD;
      end
      PH_DECODE: begin
        ctrl.alu_b_sel = SRCB_IMMS;
        ctrl.alu_mode  = ALU_ADD;
      end
      PH_ADDR: begin
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_b_sel = SRCB_IMM;
        ctrl.alu_mode  = ALU_ADD;
      end
      PH_MEMRD: begin
        ctrl.mem_rd       = 1'b1;
        ctrl.mem_addr_sel = 1'b1;
      end
      PH_LDWB: begin
        ctrl.rf_wr       = 1'b1;
        ctrl.wb_data_sel = 1'b1;
      end
      PH_MEMWR: begin
        ctrl.mem_wr       = 1'b1;
        ctrl.mem_addr_sel = 1'b1;
      end
      PH_EXEC: begin
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_b_sel = SRCB_REG;
        ctrl.alu_mode  = ALU_FUNCT;
      end
      PH_RWB: begin
        ctrl.rf_wr      = 1'b1;
        ctrl.rf_dst_sel = 1'b1;
      end
      PH_BRANCH: begin
        ctrl.alu_a_sel   = 1'b1;
        ctrl.alu_b_sel   = SRCB_REG;
        ctrl.alu_mode    = ALU_SUB;
        ctrl.pc_wr_cond  = 1'b1;
        ctrl.pc_next_sel = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
#(
  parameter int               OPC_W      = 6,
  parameter logic [OPC_W-1:0] OPC_RTYPE  = 6'h00,
  parameter logic [OPC_W-1:0] OPC_LOAD   = 6'h23,
  parameter logic [OPC_W-1:0] OPC_STORE  = 6'h2B,
  parameter logic [OPC_W-1:0] OPC_BRANCH = 6'h04
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output logic             pc_wr,
  output logic             pc_wr_cond,
  output logic             mem_addr_sel,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             ir_ld,
  output logic             wb_data_sel,
  output logic             pc_next_sel,
  output logic [1:0]       alu_mode,
  output logic             alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic             rf_wr,
  output logic             rf_dst_sel
);

  phase_e       phase_q;
  phase_e       phase_d;
  instr_class_e cls;
  ctrl_word_t   ctrl;

  mc_opc_decode #(
    .OPC_W      (OPC_W),
    .OPC_RTYPE  (OPC_RTYPE),
    .OPC_LOAD   (OPC_LOAD),
    .OPC_STORE  (OPC_STORE),
    .OPC_BRANCH (OPC_BRANCH)
  ) u_dec (
    .opcode (opcode),
    .cls    (cls)
  );

  mc_next_phase u_nxt (
    .cur (phase_q),
    .cls (cls),
    .nxt (phase_d)
  );

  mc_ctrl_outputs u_out (
    .cur  (phase_q),
    .ctrl (ctrl)
  );

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_FETCH;
    else     phase_q <= phase_d;
  end

  assign pc_wr        = ctrl.pc_wr;
  assign pc_wr_cond   = ctrl.pc_wr_cond;
  assign mem_addr_sel = ctrl.mem_addr_sel;
  assign mem_rd       = ctrl.mem_rd;
  assign mem_wr       = ctrl.mem_wr;
  assign ir_ld        = ctrl.ir_ld;
  assign wb_data_sel  = ctrl.wb_data_sel;
  assign pc_next_sel  = ctrl.pc_next_sel;
  assign alu_mode     = ctrl.alu_mode;
  assign alu_a_sel    = ctrl.alu_a_sel;
  assign alu_b_sel    = ctrl.alu_b_sel;
  assign rf_wr        = ctrl.rf_wr;
  assign rf_dst_sel   = ctrl.rf_dst_sel;

endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
module mc_ctrl_fsm_chk #(
  parameter int               OPC_W      = 6,
  parameter logic [OPC_W-1:0] OPC_RTYPE  = 6'h00,
  parameter logic [OPC_W-1:0] OPC_LOAD   = 6'h23,
  parameter logic [OPC_W-1:0] OPC_STORE  = 6'h2B,
  parameter logic [OPC_W-1:0] OPC_BRANCH = 6'h04
) (
  input logic             clk,
  input logic             rst,
  input logic [OPC_W-1:0] opcode,
  input logic             pc_wr,
  input logic             pc_wr_cond,
  input logic             mem_addr_sel,
  input logic             mem_rd,
  input logic             mem_wr,
  input logic             ir_ld,
  input logic             wb_data_sel,
  input logic [1:0]       alu_mode,
  input logic [1:0]       alu_b_sel,
  input logic             rf_wr,
  input logic             rf_dst_sel
);

  logic in_decode;
  logic opc_known;
  assign in_decode = (alu_b_sel == 2'd3);
  assign opc_known = (opcode == OPC_RTYPE) || (opcode == OPC_LOAD) ||
                     (opcode == OPC_STORE) || (opcode == OPC_BRANCH);

  AST_RESET_TO_FETCH: assert property (@(posedge clk)
    rst |=> (ir_ld && mem_rd && pc_wr)); // R1

  AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst)
    ir_ld |=> (alu_b_sel == 2'd3)); // R2

  AST_DECODE_BRANCH: assert property (@(posedge clk) disable iff (rst)
    (in_decode && opcode == OPC_BRANCH) |=> pc_wr_cond); // R3

  AST_DECODE_RTYPE: assert property (@(posedge clk) disable iff (rst)
    (in_decode && opcode == OPC_RTYPE) |=> (alu_mode == 2'd2)); // R3

  AST_LOAD_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && mem_addr_sel) |=> (rf_wr && wb_data_sel)); // R5

  AST_STORE_RETURN: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> ir_ld); // R6

  AST_EXEC_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
    (alu_mode == 2'd2) |=> (rf_wr && rf_dst_sel)); // R7

  AST_BRANCH_RETURN: assert property (@(posedge clk) disable iff (rst)
    pc_wr_cond |=> ir_ld); // R8

  AST_UNKNOWN_OPC: assert property (@(posedge clk) disable iff (rst)
    (in_decode && !opc_known) |=> ir_ld); // R9

  AST_MEM_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R11

  AST_PC_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pc_wr, pc_wr_cond})); // R11

endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk #(
  .OPC_W      (OPC_W),
  .OPC_RTYPE  (OPC_RTYPE),
  .OPC_LOAD   (OPC_LOAD),
  .OPC_STORE  (OPC_STORE),
  .OPC_BRANCH (OPC_BRANCH)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .opcode       (opcode),
  .pc_wr        (pc_wr),
  .pc_wr_cond   (pc_wr_cond),
  .mem_addr_sel (mem_addr_sel),
  .mem_rd       (mem_rd),
  .mem_wr       (mem_wr),
  .ir_ld        (ir_ld),
  .wb_data_sel  (wb_data_sel),
  .alu_mode     (alu_mode),
  .alu_b_sel    (alu_b_sel),
  .rf_wr        (rf_wr),
  .rf_dst_sel   (rf_dst_sel)
);

// File: tb/mc_ctrl_fsm_tb.sv
`timescale 1ns/1ps
module mc_ctrl_fsm_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic       pc_wr, pc_wr_cond, mem_addr_sel, mem_rd, mem_wr, ir_ld;
  logic       wb_data_sel, pc_next_sel, alu_a_sel, rf_wr, rf_dst_sel;
  logic [1:0] alu_mode, alu_b_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [14:0] q_word[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  mc_ctrl_fsm u_dut (
    .clk(clk), .rst(rst), .opcode(opcode),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .mem_addr_sel(mem_addr_sel),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_ld(ir_ld),
    .wb_data_sel(wb_data_sel), .pc_next_sel(pc_next_sel),
    .alu_mode(alu_mode), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
    .rf_wr(rf_wr), .rf_dst_sel(rf_dst_sel)
  );

  // bit order: pc_wr pc_wr_cond mem_addr_sel mem_rd mem_wr ir_ld
  //            wb_data_sel pc_next_sel alu_mode[1:0] alu_a_sel alu_b_sel[1:0] rf_wr rf_dst_sel
  function automatic logic [14:0] observed();
    return {pc_wr, pc_wr_cond, mem_addr_sel, mem_rd, mem_wr, ir_ld,
            wb_data_sel, pc_next_sel, alu_mode, alu_a_sel, alu_b_sel,
            rf_wr, rf_dst_sel};
  endfunction

  function automatic logic [14:0] mk(bit pw, bit pc, bit asel, bit mr, bit mw,
                                     bit il, bit wb, bit ps, logic [1:0] am,
                                     bit a, logic [1:0] b, bit rw, bit rd);
    return {pw, pc, asel, mr, mw, il, wb, ps, am, a, b, rw, rd};
  endfunction

  // Expected control word per phase, taken from the requirement text.
  function automatic logic [14:0] expect_of(int ph);
    case (ph)
      0: return mk(1,0,0,1,0,1,0,0,2'd0,0,2'd1,0,0); // R2 fetch
      1: return mk(0,0,0,0,0,0,0,0,2'd0,0,2'd3,0,0); // R3 decode
      2: return mk(0,0,0,0,0,0,0,0,2'd0,1,2'd2,0,0); // R4 address
      3: return mk(0,0,1,1,0,0,0,0,2'd0,0,2'd0,0,0); // R5 memory read
      4: return mk(0,0,0,0,0,0,1,0,2'd0,0,2'd0,1,0); // R5 load writeback
      5: return mk(0,0,1,0,1,0,0,0,2'd0,0,2'd0,0,0); // R6 memory write
      6: return mk(0,0,0,0,0,0,0,0,2'd2,1,2'd0,0,0); // R7 execute
      7: return mk(0,0,0,0,0,0,0,0,2'd0,0,2'd0,1,1); // R7 register writeback
      8: return mk(0,1,0,0,0,0,0,1,2'd1,1,2'd0,0,0); // R8 branch
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(int ph);
    case (ph)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3, 4: return "R5";
      5: return "R6";
      6, 7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check_now(string tag, logic [14:0] exp_w);
    checks++;
    if (observed() !== exp_w) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, observed(), exp_w);
    end
  endtask

  // Driver: called one time unit after the edge that entered fetch.
  task automatic run_instr(logic [5:0] op, bit scramble, logic [5:0] junk);
    int seq[5];
    int len;
    int hold;
    len = 0;
    hold = 2;
    case (op)
      6'h23: begin seq = '{0,1,2,3,4}; len = 5; hold = 3; end
      6'h2B: begin seq = '{0,1,2,5,0}; len = 4; hold = 3; end
      6'h00: begin seq = '{0,1,6,7,0}; len = 4; end
      6'h04: begin seq = '{0,1,8,0,0}; len = 3; end
      default: begin seq = '{0,1,0,0,0}; len = 2; end // R9
    endcase
    opcode = op;
    for (int i = 0; i < len; i++) begin
      q_word.push_back(expect_of(seq[i]));
      if (scramble && i >= hold) q_tag.push_back("R10");
      else if (len == 2 && i == 1) q_tag.push_back("R9");
      else q_tag.push_back(tag_of(seq[i]));
    end
    for (int i = 0; i < len; i++) begin
      @(posedge clk);
      #1;
      if (scramble && i + 1 >= hold) opcode = junk;
    end
  endtask

  // Monitor: compares one queued word per cycle, mid-cycle.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        checks++;
        if (mem_rd && mem_wr) begin
          fails++;
          $display("FAIL R11: actual mem_rd=%b mem_wr=%b expected not both", mem_rd, mem_wr);
        end
        if (q_word.size() > 0) begin
          logic [14:0] w;
          string t;
          w = q_word.pop_front();
          t = q_tag.pop_front();
          check_now(t, w);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_now("R1", expect_of(0)); // reset shows fetch levels
    @(posedge clk);
    #1 rst = 1'b0;

    run_instr(6'h23, 0, 6'h00);    // R5 load
    run_instr(6'h2B, 0, 6'h00);    // R6 store
    run_instr(6'h00, 0, 6'h00);    // R7 register form
    run_instr(6'h04, 0, 6'h00);    // R8 branch
    run_instr(6'h3F, 0, 6'h00);    // R9 unknown opcode
    run_instr(6'h11, 0, 6'h00);    // R9 another unknown opcode
    run_instr(6'h23, 1, 6'h04);    // R10 opcode changes during load tail
    run_instr(6'h00, 1, 6'h2B);    // R10 opcode changes during writeback
    run_instr(6'h2B, 1, 6'h23);    // R10 opcode changes during store
    run_instr(6'h04, 1, 6'h00);    // R10 opcode changes at branch end
    run_instr(6'h04, 0, 6'h00);    // R8 back to back branches
    run_instr(6'h04, 0, 6'h00);

    // R1: reset in the middle of a load (address phase)
    opcode = 6'h23;
    @(posedge clk); #1;
    @(posedge clk); #1;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_now("R1", expect_of(0));
    @(posedge clk);
    #1 rst = 1'b0;
    run_instr(6'h00, 0, 6'h00);    // R2 restart after mid-instruction reset
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule